// File: doc/BRIEF.md
# Extended State Observer Controller

This block is a fixed-point, discrete-time controller for a second-order plant, such as the output filter of a switching power stage. Each sample strobe delivers a signed measurement and a setpoint. The block then does two things. First, it computes a duty command from its current estimates. Second, it advances a three-state observer.

The observer keeps three estimates:
- the plant output;
- the output's rate of change, scaled by the sample period;
- a lumped disturbance term that collects unmodelled dynamics and external upsets, scaled by the square of the sample period.

The command is a PD law on the estimated output and rate, minus the disturbance estimate, scaled by the inverse of the nominal input gain. It is clamped to a safe duty window.

Tuning takes only two inputs: an observer bandwidth and a loop bandwidth, both already multiplied by the sample period. The block derives all five loop gains from these two values. The nominal input gain and its inverse arrive already computed. All arithmetic is signed Q-format with 12 fractional bits on 32-bit words. One evaluation takes three clock cycles, which is far inside a 50 us sample period at any practical clock rate.

Top module: `dist_rej_ctrl`

## Requirements
- R1: While rst_ni is low, duty_o is 0 and valid_o is 0, and all three estimates are cleared. After reset, the first command is therefore computed from zero estimates.
- R2: A strobe is accepted only when the block is idle. A strobe on the two rising edges after an accepted one is ignored: it produces no extra valid_o pulse and no extra observer update.
- R3: A strobe accepted at rising edge k causes duty_o to take its new value at edge k+1, with valid_o high for exactly that one cycle. duty_o holds its value at all other times, whatever the inputs do.
- R4: From wo_i and wc_i (unsigned Q12, value = raw/4096), the block derives its gains with every product floored to Q12. The observer gains are 3·wo, 3·wo² and wo³. The PD gains are kp = wc² and kd = 2·wc.
- R5: The raw command is u = binv·(kp·(r − z1) − kd·z2 − z3). It is computed from the estimates held before this sample's observer update.
- R6: The emitted command is u clamped to the range 0 to 3891 (0.95 · 4096, floored). Negative values give 0.
- R7: At edge k+2, the observer advances using e = y − z1 and the emitted duty d:
  - z1 += z2 + l1·e
  - z2 += z3 + b0·d + l2·e
  - z3 += l3·e
- R8: Every sum and product saturates to the signed 32-bit range instead of wrapping. A product is taken as the full 64-bit value shifted right by 12, then saturated.
- R9: y_i and r_i are integer counts. They are promoted to Q12 by a left shift of 12. The inputs are sampled on the accepting edge only, so changes during the computation are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Sample strobe |
| y_i | input | MEAS_W | Signed plant measurement, integer counts |
| r_i | input | MEAS_W | Signed setpoint, integer counts |
| wo_i | input | BW_W | Observer bandwidth × period, unsigned Q12 |
| wc_i | input | BW_W | Loop bandwidth × period, unsigned Q12 |
| b0_i | input | BW_W | Nominal input gain × period², unsigned Q12 |
| b0_inv_i | input | BW_W | Inverse of b0_i, unsigned Q12 |
| duty_o | output | 13 | Duty command, Q12 of full scale |
| valid_o | output | 1 | One-cycle pulse marking a new duty_o |

## Verification
Results follow a fixed schedule:
- A strobe seen at rising edge k makes duty_o and valid_o change at edge k+1.
- The observer state that feeds the next command is written at edge k+2.
- The next strobe can be accepted at edge k+3.

The bench drives inputs and reads outputs only on falling edges. It checks that valid_o is still low half a cycle after edge k, high with the expected duty half a cycle after edge k+1, and low again after edge k+2. A reference model in the bench, written from the fixed-point rules, predicts every duty value and advances its own estimates once per accepted strobe. Ignored strobes and held outputs are therefore seen as mismatches in later commands.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam int unsigned ACC_W    = 32;
  localparam int unsigned FRAC     = 12;
  localparam int unsigned WIDE_W   = ACC_W + 2;
  localparam int unsigned PROD_W   = 2 * ACC_W;
  localparam int unsigned DUTY_PCT = 95;
  localparam int unsigned DUTY_W   = FRAC + 1;

  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic signed [WIDE_W-1:0] wide_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic        [DUTY_W-1:0] duty_t;

  typedef struct packed {
    acc_t z1;
    acc_t z2;
    acc_t z3;
  } est_t;

  typedef struct packed {
    acc_t l1;
    acc_t l2;
    acc_t l3;
    acc_t kp;
    acc_t kd;
  } gain_t;

  localparam acc_t  ACC_MAX    = {1'b0, {(ACC_W-1){1'b1}}};
  localparam acc_t  ACC_MIN    = {1'b1, {(ACC_W-1){1'b0}}};
  localparam duty_t DUTY_MAX   = duty_t'((DUTY_PCT << FRAC) / 100);
  localparam acc_t  DUTY_MAX_Q = {{(ACC_W-DUTY_W){1'b0}}, DUTY_MAX};

  function automatic acc_t sat_wide(input wide_t v);
    if (v[WIDE_W-1:ACC_W-1] == {(WIDE_W-ACC_W+1){v[WIDE_W-1]}})
      return acc_t'(v[ACC_W-1:0]);
    else if (v[WIDE_W-1])
      return ACC_MIN;
    else
      return ACC_MAX;
  endfunction

  function automatic acc_t qmul(input acc_t a, input acc_t b);
    prod_t p;
    p = prod_t'(a) * prod_t'(b);
    p = p >>> FRAC;
    if (p[PROD_W-1:ACC_W-1] == {(PROD_W-ACC_W+1){p[PROD_W-1]}})
      return acc_t'(p[ACC_W-1:0]);
    else if (p[PROD_W-1])
      return ACC_MIN;
    else
      return ACC_MAX;
  endfunction

  function automatic acc_t add3(input acc_t a, input acc_t b, input acc_t c);
    return sat_wide(wide_t'(a) + wide_t'(b) + wide_t'(c));
  endfunction

  function automatic acc_t add4(input acc_t a, input acc_t b, input acc_t c, input acc_t d);
    return sat_wide(wide_t'(a) + wide_t'(b) + wide_t'(c) + wide_t'(d));
  endfunction

  function automatic acc_t sub2(input acc_t a, input acc_t b);
    return sat_wide(wide_t'(a) - wide_t'(b));
  endfunction
endpackage

// File: rtl/dr_gain_calc.sv
module dr_gain_calc
  import dr_pkg::*;
#(
  parameter int unsigned BW_W = 16
) (
  input  logic [BW_W-1:0] wo_i,
  input  logic [BW_W-1:0] wc_i,
  output gain_t           gain_o
);
  localparam int unsigned PAD_W = ACC_W - BW_W;

  acc_t ho, hc, ho_sq;

  assign ho    = acc_t'({{PAD_W{1'b0}}, wo_i});
  assign hc    = acc_t'({{PAD_W{1'b0}}, wc_i});
  assign ho_sq = qmul(ho, ho);

  always_comb begin
    gain_o.l1 = add3(ho, ho, ho);
    gain_o.l2 = add3(ho_sq, ho_sq, ho_sq);
    gain_o.l3 = qmul(ho_sq, ho);
    gain_o.kp = qmul(hc, hc);
    gain_o.kd = add3(hc, hc, '0);
  end
endmodule

// File: rtl/dr_law.sv
module dr_law
  import dr_pkg::*;
#(
  parameter int unsigned MEAS_W = 16
) (
  input  logic signed [MEAS_W-1:0] r_i,
  input  est_t                     est_i,
  input  gain_t                    gain_i,
  input  acc_t                     binv_i,
  output duty_t                    duty_o
);
  acc_t r_q, err, pd, unscaled, u_raw;

  assign r_q      = acc_t'(r_i) <<< FRAC;
  assign err      = sub2(r_q, est_i.z1);
  assign pd       = sub2(qmul(gain_i.kp, err), qmul(gain_i.kd, est_i.z2));
  assign unscaled = sub2(pd, est_i.z3);
  assign u_raw    = qmul(binv_i, unscaled);

  always_comb begin
    if (u_raw < 0)                duty_o = '0;
    else if (u_raw > DUTY_MAX_Q)  duty_o = DUTY_MAX;
    else                          duty_o = u_raw[DUTY_W-1:0];
  end
endmodule

// File: rtl/dr_observer.sv
module dr_observer
  import dr_pkg::*;
#(
  parameter int unsigned MEAS_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     upd_i,
  input  logic signed [MEAS_W-1:0] y_i,
  input  duty_t                    duty_i,
  input  gain_t                    gain_i,
  input  acc_t                     b0_i,
  output est_t                     est_o
);
  est_t est_q, est_d;
  acc_t y_q, innov, b_u;

  assign y_q   = acc_t'(y_i) <<< FRAC;
  assign innov = sub2(y_q, est_q.z1);
  assign b_u   = qmul(b0_i, acc_t'({{(ACC_W-DUTY_W){1'b0}}, duty_i}));

  always_comb begin
    est_d.z1 = add3(est_q.z1, est_q.z2, qmul(gain_i.l1, innov));
    est_d.z2 = add4(est_q.z2, est_q.z3, b_u, qmul(gain_i.l2, innov));
    est_d.z3 = add3(est_q.z3, qmul(gain_i.l3, innov), '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    est_q <= '0;
    else if (upd_i) est_q <= est_d;
  end

  assign est_o = est_q;
endmodule

// File: rtl/dist_rej_ctrl.sv
module dist_rej_ctrl
  import dr_pkg::*;
#(
  parameter int unsigned MEAS_W = 16,
  parameter int unsigned BW_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_i,
  input  logic signed [MEAS_W-1:0] y_i,
  input  logic signed [MEAS_W-1:0] r_i,
  input  logic [BW_W-1:0]          wo_i,
  input  logic [BW_W-1:0]          wc_i,
  input  logic [BW_W-1:0]          b0_i,
  input  logic [BW_W-1:0]          b0_inv_i,
  output logic [DUTY_W-1:0]        duty_o,
  output logic                     valid_o
);
  localparam int unsigned PAD_W = ACC_W - BW_W;

  typedef enum logic [1:0] {ST_IDLE, ST_LAW, ST_OBS} st_e;

  st_e                     st_q;
  logic signed [MEAS_W-1:0] y_q, r_q;
  logic [BW_W-1:0]          wo_q, wc_q, b0_q, binv_q;
  gain_t                    gain;
  est_t                     est;
  duty_t                    law_duty;
  acc_t                     b0_ext, binv_ext;

  assign b0_ext   = acc_t'({{PAD_W{1'b0}}, b0_q});
  assign binv_ext = acc_t'({{PAD_W{1'b0}}, binv_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      y_q     <= '0;
      r_q     <= '0;
      wo_q    <= '0;
      wc_q    <= '0;
      b0_q    <= '0;
      binv_q  <= '0;
      duty_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (sample_i) begin
          y_q    <= y_i;
          r_q    <= r_i;
          wo_q   <= wo_i;
          wc_q   <= wc_i;
          b0_q   <= b0_i;
          binv_q <= b0_inv_i;
          st_q   <= ST_LAW;
        end
        ST_LAW: begin
          duty_o  <= law_duty;
          valid_o <= 1'b1;
          st_q    <= ST_OBS;
        end
        ST_OBS:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  dr_gain_calc #(.BW_W(BW_W)) i_gain (
    .wo_i  (wo_q),
    .wc_i  (wc_q),
    .gain_o(gain)
  );

  dr_law #(.MEAS_W(MEAS_W)) i_law (
    .r_i   (r_q),
    .est_i (est),
    .gain_i(gain),
    .binv_i(binv_ext),
    .duty_o(law_duty)
  );

  // observer consumes the command already on duty_o
  dr_observer #(.MEAS_W(MEAS_W)) i_obs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (st_q == ST_OBS),
    .y_i   (y_q),
    .duty_i(duty_o),
    .gain_i(gain),
    .b0_i  (b0_ext),
    .est_o (est)
  );
endmodule

// File: rtl/dr_ctrl_chk.sv
module dr_ctrl_chk
  import dr_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  sample_i,
  input logic  valid_o,
  input duty_t duty_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (duty_o == '0 && !valid_o);
    end
  end

  // R3
  valid_after_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(sample_i, 2));

  // R2
  pulse_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!$past(valid_o) && !$past(valid_o, 2)));

  // R3
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(duty_o));

  // R6
  duty_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_o <= DUTY_MAX);
endmodule

bind dist_rej_ctrl dr_ctrl_chk i_dr_ctrl_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sample_i(sample_i),
  .valid_o (valid_o),
  .duty_o  (duty_o)
);

// File: tb/test_dist_rej_ctrl.sv
module test_dist_rej_ctrl;
  localparam longint DMAX = 3891;

  logic               clk = 1'b0;
  logic               rst_n = 1'b1;
  logic               sample = 1'b0;
  logic signed [15:0] y = '0;
  logic signed [15:0] r = '0;
  logic [15:0]        wo = 16'd819;
  logic [15:0]        wc = 16'd410;
  logic [15:0]        b0 = 16'd4096;
  logic [15:0]        binv = 16'd4096;
  logic [12:0]        duty;
  logic               valid;

  int     n_vec = 0;
  int     n_err = 0;
  longint mz1 = 0, mz2 = 0, mz3 = 0;

  always #5 clk = ~clk;

  dist_rej_ctrl i_dist_rej_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .y_i(y), .r_i(r),
    .wo_i(wo), .wc_i(wc), .b0_i(b0), .b0_inv_i(binv),
    .duty_o(duty), .valid_o(valid)
  );

  function automatic longint sat(input longint v);
    if (v > 64'sd2147483647)  return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic longint qm(input longint a, input longint b);
    return sat((a * b) >>> 12);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference: command from current estimates, then one estimate step
  task automatic model_step(input longint yv, input longint rv, output longint d);
    longint ho, hc, h2, l1, l2, l3, kp, kd, er, pd, un, uf, e, bu, n1, n2, n3;
    ho = longint'(wo); hc = longint'(wc);
    h2 = qm(ho, ho);
    l1 = sat(3 * ho); l2 = sat(3 * h2); l3 = qm(h2, ho);
    kp = qm(hc, hc);  kd = sat(2 * hc);
    er = sat(rv * 4096 - mz1);
    pd = sat(qm(kp, er) - qm(kd, mz2));
    un = sat(pd - mz3);
    uf = qm(longint'(binv), un);
    d  = (uf < 0) ? 0 : ((uf > DMAX) ? DMAX : uf);
    e  = sat(yv * 4096 - mz1);
    bu = qm(longint'(b0), d);
    n1 = sat(mz1 + mz2 + qm(l1, e));
    n2 = sat(mz2 + mz3 + bu + qm(l2, e));
    n3 = sat(mz3 + qm(l3, e));
    mz1 = n1; mz2 = n2; mz3 = n3;
  endtask

  task automatic run_sample(input longint yv, input longint rv, input string tag,
                            output longint d);
    y = 16'(yv); r = 16'(rv); sample = 1'b1;
    model_step(yv, rv, d);
    @(negedge clk); sample = 1'b0;
    chk({tag, " R3 no early valid"}, valid, 0);
    @(negedge clk);
    chk({tag, " R3 valid pulse"}, valid, 1);
    chk({tag, " duty"}, duty, d);
    @(negedge clk);
    chk({tag, " R3 valid drops"}, valid, 0);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk({tag, " R1 duty"}, duty, 0);
    chk({tag, " R1 valid"}, valid, 0);
    rst_n = 1'b1; mz1 = 0; mz2 = 0; mz3 = 0;
    @(negedge clk);
  endtask

  task automatic t_first;
    longint d;
    run_sample(0, 5, "R5 R9 first", d);
    chk("R5 first explicit", d, 205);
  endtask

  task automatic t_track;
    longint d;
    for (int i = 0; i < 12; i++) begin
      run_sample(((i * 37) % 200) - 60, 40 + (i % 3) * 10, "R4 R5 R7 track", d);
    end
  endtask

  task automatic t_clamp;
    longint d;
    run_sample(10, 30000, "R6 high", d);
    chk("R6 high explicit", duty, DMAX);
    run_sample(10, -30000, "R6 low", d);
    chk("R6 low explicit", duty, 0);
  endtask

  task automatic t_busy;
    longint d;
    int pulses = 0;
    y = 16'sd20; r = 16'sd60; sample = 1'b1;
    model_step(20, 60, d);
    @(negedge clk); y = -16'sd500; r = 16'sd3000;
    @(negedge clk);
    chk("R2 busy duty", duty, d);
    pulses += int'(valid);
    y = 16'sd700; r = -16'sd3000;
    @(negedge clk); sample = 1'b0;
    for (int i = 0; i < 5; i++) begin
      pulses += int'(valid);
      @(negedge clk);
    end
    chk("R2 one pulse", pulses, 1);
    run_sample(15, 60, "R2 after busy", d);
  endtask

  task automatic t_hold;
    logic [12:0] held;
    held = duty;
    y = -16'sd9000; r = 16'sd9000;
    repeat (4) begin
      @(negedge clk);
      chk("R3 R9 hold duty", duty, held);
      chk("R3 hold valid", valid, 0);
    end
  endtask

  task automatic t_sat;
    longint d;
    wo = 16'hFFFF; wc = 16'hFFFF; b0 = 16'hFFFF; binv = 16'hFFFF;
    for (int i = 0; i < 6; i++) begin
      run_sample((i % 2 == 0) ? 32767 : -32768, (i % 3 == 0) ? -32768 : 32767, "R8 sat", d);
    end
    wo = 16'd819; wc = 16'd410; b0 = 16'd4096; binv = 16'd4096;
  endtask

  initial begin
    #3 rst_n = 1'b0;
    #20;
    chk("R1 reset duty", duty, 0);
    chk("R1 reset valid", valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_first();
    t_track();
    t_hold();
    t_clamp();
    t_busy();
    t_sat();
    do_reset("mid-run");
    t_first();
    t_track();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule